// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level Interrupts

This block sits between a processor register port and a serial audio engine. It holds one queue of 32-bit samples heading out to the serializer and one queue of samples arriving from the deserializer. Software fills the outgoing queue and drains the incoming queue through plain word registers. It reads both fill levels from one packed status word. It is told by an interrupt line when the outgoing queue has room, when the serializer ran dry, or when received data is waiting.

The serializer side uses a simple pop strobe with a valid flag. The deserializer side uses a push strobe. Each queue can be emptied by a self-clearing flush bit. A 7-bit trigger level sets how much free room the outgoing queue must have before its room interrupt asserts. Two sample counters track traffic on each side, and software can load them, which includes clearing them to zero. Serial timing, clock division and DMA handshakes belong to neighbouring blocks.

Top module: `audio_fifo_regs`

## Requirements
- R1: Word register index map (reg_addr): 0 control, 1 levels, 2 interrupt status, 3 interrupt enable, 4 TX data (write), 5 RX data (read), 6 TX sample count, 7 RX sample count. After reset the levels word reads 0x00800000 (128 free, 0 available), status and enable read 0, control bits 18:12 read 64, and irq is low.
- R2: Words written to TX data leave on tx_data in write order, one for each cycle tx_pop is high while tx_valid is high. The levels word bits 23:16 hold the number of free TX entries.
- R3: A write to TX data while the TX queue holds 128 words is dropped, and the free count stays 0.
- R4: Words pushed with rx_push are returned in order by reads of RX data, and the levels word bits 5:0 hold the stored count. A read with nothing stored returns 0 and changes nothing. A push into a full queue of 32 is dropped.
- R5: Writing control bit 25 empties the TX queue and writing bit 24 empties the RX queue in the next cycle. Neither bit is stored (both read 0), and a flush leaves the other queue untouched.
- R6: Control bits 18:12 hold the TX trigger level. Status bit 4 (TX room) sets in the cycle after the free count is at or above that level.
- R7: A tx_pop while the TX queue is empty sets status bit 6 (underrun) and tx_data reads 0.
- R8: Status bit 1 is unused, and status bit 0 (RX data) sets in the cycle after at least one RX word is stored.
- R9: Writing 1 to a status bit clears it unless its set condition holds that cycle, in which case it stays set. Writing 0 leaves the bit as it is.
- R10: irq is high when any of status bits 6, 4 or 0 is set together with the enable bit at the same position in the enable register.
- R11: The TX sample count rises by one for each word taken by tx_pop. The RX sample count rises by one for each accepted push. A write to either counter loads the written value, so writing 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at index 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| tx_pop | input | 1 | Serializer takes one TX word |
| tx_valid | output | 1 | TX queue holds at least one word |
| tx_data | output | 32 | Head TX word, 0 when empty |
| rx_push | input | 1 | Deserializer offers one RX word |
| rx_data | input | 32 | RX word to store |
| irq | output | 1 | Combined interrupt request |

## Verification
Several checks run on every cycle: the queue counts stay within their depths, a write into a full TX queue leaves the count unchanged, a flush empties its queue at the next edge, an empty-queue pop raises underrun, and the room and data-waiting status bits follow their conditions one cycle later. Other behaviour is shown only by the bench's scenarios. These are data order through each queue, packing of the levels word, the set-wins-over-clear rule, threshold reprogramming, the interrupt masking, and the counter totals after full, overfull and flushed traffic.

// File: rtl/audio_fifo_regs.sv
module audio_fifo_regs #(
  parameter int DW       = 32,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 32,
  parameter int THR_RST  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_pop,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          irq
);
  localparam int TXAW = $clog2(TX_DEPTH);
  localparam int RXAW = $clog2(RX_DEPTH);
  localparam int TXCW = TXAW + 1;
  localparam int RXCW = RXAW + 1;
  localparam logic [TXCW-1:0] TX_FULL = TXCW'(TX_DEPTH);
  localparam logic [RXCW-1:0] RX_FULL = RXCW'(RX_DEPTH);

  localparam logic [2:0] A_CTRL = 3'd0, A_LVL = 3'd1, A_STS = 3'd2, A_EN = 3'd3,
                         A_TXD = 3'd4, A_RXD = 3'd5, A_TXC = 3'd6, A_RXC = 3'd7;

  logic [DW-1:0]   tx_mem [TX_DEPTH];
  logic [DW-1:0]   rx_mem [RX_DEPTH];
  logic [TXAW-1:0] tx_wp, tx_rp;
  logic [RXAW-1:0] rx_wp, rx_rp;
  logic [TXCW-1:0] tx_cnt, tx_free;
  logic [RXCW-1:0] rx_cnt;
  logic [6:0]      thr;
  logic [2:0]      sts, en, sts_set, sts_clr;
  logic [31:0]     tx_smp, rx_smp;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire tx_flush = wr_ctrl && reg_wdata[25];
  wire rx_flush = wr_ctrl && reg_wdata[24];
  wire tx_put   = reg_wr && reg_addr == A_TXD && tx_cnt != TX_FULL;
  wire tx_take  = tx_pop && tx_cnt != '0;
  wire rx_put   = rx_push && rx_cnt != RX_FULL;
  wire rx_take  = reg_rd && reg_addr == A_RXD && rx_cnt != '0;

  assign tx_free  = TX_FULL - tx_cnt;
  assign tx_valid = tx_cnt != '0;
  assign tx_data  = tx_valid ? tx_mem[tx_rp] : '0;
  assign irq      = |(sts & en);

  // status vector order: [2] underrun (bit 6), [1] tx room (bit 4), [0] rx data (bit 0)
  assign sts_set = {tx_pop && tx_cnt == '0,
                    32'(tx_free) >= 32'(thr),
                    rx_cnt != '0};
  assign sts_clr = (reg_wr && reg_addr == A_STS) ?
                   {reg_wdata[6], reg_wdata[4], reg_wdata[0]} : 3'b000;

  always_ff @(posedge clk) begin
    if (tx_put) tx_mem[tx_wp] <= reg_wdata[DW-1:0];
    if (rx_put) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_put)  tx_wp <= tx_wp + 1'b1;
      if (tx_take) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + TXCW'(tx_put) - TXCW'(tx_take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_put)  rx_wp <= rx_wp + 1'b1;
      if (rx_take) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + RXCW'(rx_put) - RXCW'(rx_take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr    <= 7'(THR_RST);
      sts    <= '0;
      en     <= '0;
      tx_smp <= '0;
      rx_smp <= '0;
    end else begin
      if (wr_ctrl) thr <= reg_wdata[18:12];
      if (reg_wr && reg_addr == A_EN) en <= {reg_wdata[6], reg_wdata[4], reg_wdata[0]};
      sts <= (sts & ~sts_clr) | sts_set;
      if (reg_wr && reg_addr == A_TXC) tx_smp <= reg_wdata;
      else if (tx_take)                tx_smp <= tx_smp + 1'b1;
      if (reg_wr && reg_addr == A_RXC) rx_smp <= reg_wdata;
      else if (rx_put)                 rx_smp <= rx_smp + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[18:12] = thr;
      A_LVL: begin
        reg_rdata[23:16] = 8'(tx_free);
        reg_rdata[5:0]   = 6'(rx_cnt);
      end
      A_STS: begin
        reg_rdata[6] = sts[2];
        reg_rdata[4] = sts[1];
        reg_rdata[0] = sts[0];
      end
      A_EN: begin
        reg_rdata[6] = en[2];
        reg_rdata[4] = en[1];
        reg_rdata[0] = en[0];
      end
      A_RXD:   reg_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : '0;
      A_TXC:   reg_rdata = tx_smp;
      A_RXC:   reg_rdata = rx_smp;
      default: reg_rdata = '0;
    endcase
  end

  p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_FULL);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXD && tx_cnt == TX_FULL && !tx_pop) |=> $stable(tx_cnt));

  p_rx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_FULL);

  p_rx_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RXD && rx_cnt == '0) |-> reg_rdata == '0);

  p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[25]) |=> tx_cnt == '0);

  p_rx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[24]) |=> rx_cnt == '0);

  p_room_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_free) >= 32'(thr)) |=> sts[1]);

  p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !tx_valid) |=> sts[2]);

  p_rxdata_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0) |=> sts[0]);
endmodule

// File: tb/audio_fifo_regs_bench.sv
module audio_fifo_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tx_pop = 1'b0, tx_valid;
  logic [31:0] tx_data;
  logic        rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic        irq;

  int checks = 0, failures = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  audio_fifo_regs u_audio_fifo_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && tx_pop) begin
      logic [31:0] e;
      e = (txq.size() != 0) ? txq.pop_front() : 32'h0;
      chk(tx_data == e, "R2/R7 tx_data", tx_data, e);
    end
    if (rst_n && reg_rd && reg_addr == 3'd5) begin
      logic [31:0] e;
      e = (rxq.size() != 0) ? rxq.pop_front() : 32'h0;
      chk(reg_rdata == e, "R4 rx read", reg_rdata, e);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic tx_write(input logic [31:0] d);
    if (txq.size() < 128) txq.push_back(d);
    wr(3'd4, d);
  endtask

  task automatic tx_pops(input int n);
    tx_pop = 1'b1;
    repeat (n) step();
    tx_pop = 1'b0;
  endtask

  task automatic rx_send(input logic [31:0] d);
    if (rxq.size() < 32) rxq.push_back(d);
    rx_push = 1'b1; rx_data = d;
    step();
    rx_push = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state, read combinationally while reset held
    repeat (3) @(posedge clk);
    #1;
    reg_rd = 1'b1;
    reg_addr = 3'd2; #1; chk(reg_rdata == 0, "R1 status", reg_rdata, 0);
    reg_addr = 3'd1; #1; chk(reg_rdata == 32'h0080_0000, "R1 levels", reg_rdata, 32'h0080_0000);
    reg_addr = 3'd0; #1; chk(reg_rdata[18:12] == 7'd64, "R1 threshold", 32'(reg_rdata[18:12]), 64);
    reg_addr = 3'd3; #1; chk(reg_rdata == 0, "R1 enable", reg_rdata, 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    reg_rd = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    step();

    // R6 room status after reset, R10 enable
    rdreg(3'd2, rd); chk(rd[4] == 1'b1, "R6 room set", rd, 32'h10);
    chk(irq == 1'b0, "R10 masked", 32'(irq), 0);
    wr(3'd3, 32'h10); step();
    chk(irq == 1'b1, "R10 irq room", 32'(irq), 1);
    wr(3'd0, 32'(127) << 12);
    wr(3'd2, 32'h10);
    rdreg(3'd2, rd); chk(rd[4] == 1'b1, "R9 set wins", rd, 32'h10);
    tx_write(32'hA1A1_0001);
    tx_write(32'hB2B2_0002);
    wr(3'd2, 32'h10);
    rdreg(3'd2, rd); chk(rd[4] == 1'b0, "R6 below level", 32'(rd[4]), 0);
    chk(irq == 1'b0, "R10 irq cleared", 32'(irq), 0);
    rdreg(3'd1, rd); chk(rd[23:16] == 8'd126, "R2 free count", 32'(rd[23:16]), 126);
    tx_pops(2);
    rdreg(3'd1, rd); chk(rd[23:16] == 8'd128, "R2 free after pop", 32'(rd[23:16]), 128);

    // R7 underrun, R9 write-one-to-clear
    tx_pops(1);
    step();
    rdreg(3'd2, rd); chk(rd[6] == 1'b1, "R7 underrun", rd, 32'h40);
    wr(3'd2, 32'h01);
    rdreg(3'd2, rd); chk(rd[6] == 1'b1, "R9 other bit", 32'(rd[6]), 1);
    wr(3'd2, 32'h40);
    rdreg(3'd2, rd); chk(rd[6] == 1'b0, "R9 cleared", 32'(rd[6]), 0);

    // R3 full TX queue
    for (int i = 0; i < 129; i++) tx_write(32'hC000_0000 + 32'(i));
    rdreg(3'd1, rd); chk(rd == 32'h0, "R3 full levels", rd, 0);
    tx_pops(128);
    chk(tx_valid == 1'b0, "R3 drained", 32'(tx_valid), 0);
    rdreg(3'd6, rd); chk(rd == 32'd130, "R11 tx count", rd, 130);
    wr(3'd6, 32'h0);
    rdreg(3'd6, rd); chk(rd == 32'd0, "R11 tx count clear", rd, 0);

    // R4/R8 receive path
    wr(3'd3, 32'h01); step();
    chk(irq == 1'b0, "R8 idle irq", 32'(irq), 0);
    rx_send(32'h1111_0001); rx_send(32'h2222_0002); rx_send(32'h3333_0003);
    step();
    chk(irq == 1'b1, "R8 data irq", 32'(irq), 1);
    rdreg(3'd1, rd); chk(rd[5:0] == 6'd3, "R4 rx level", 32'(rd[5:0]), 3);
    for (int i = 0; i < 4; i++) rdreg(3'd5, rd);
    chk(rd == 32'h0, "R4 empty read", rd, 0);
    wr(3'd2, 32'h01); step();
    chk(irq == 1'b0, "R9 rx clear", 32'(irq), 0);
    for (int i = 0; i < 33; i++) rx_send(32'hD000_0000 + 32'(i));
    rdreg(3'd1, rd); chk(rd[5:0] == 6'd32, "R4 full drop", 32'(rd[5:0]), 32);
    rdreg(3'd7, rd); chk(rd == 32'd35, "R11 rx count", rd, 35);

    // R5 flushes
    wr(3'd0, (32'(64) << 12) | 32'h0100_0000);
    rxq.delete();
    rdreg(3'd1, rd); chk(rd[5:0] == 6'd0, "R5 rx flush", 32'(rd[5:0]), 0);
    rdreg(3'd0, rd); chk(rd[25:24] == 2'b00, "R5 self clear", rd, 32'(64) << 12);
    rx_send(32'hEEEE_0001); rx_send(32'hEEEE_0002);
    for (int i = 0; i < 5; i++) tx_write(32'hF000_0000 + 32'(i));
    wr(3'd0, (32'(64) << 12) | 32'h0200_0000);
    txq.delete();
    rdreg(3'd1, rd); chk(rd == 32'h0080_0002, "R5 tx flush only", rd, 32'h0080_0002);
    rdreg(3'd5, rd); rdreg(3'd5, rd);
    chk(tx_valid == 1'b0, "R5 tx empty", 32'(tx_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule